// File: doc/BRIEF.md
# Access-Aware Staggered Refresh Tracker

This block sits in a DRAM memory controller and decides which rows need an explicit refresh. Each row owns a small countdown counter. A periodic update tick walks the row indices one at a time. For the current index it visits that index in every logical segment, one segment per clock, and lowers the counter. A row whose counter reaches zero has gone a full retention interval without being opened, so its address is queued as a row-addressed refresh request. Rows that normal traffic activates, and rows whose refresh has completed, get their counters reloaded to the maximum. This way rows in active use are never refreshed needlessly.

Counters leave reset at staggered values, and the walker touches only one index per tick. Because of this, at most one request per segment can fall due on any tick, and expiries do not bunch into a burst. The tick period must cover the whole sweep and the time needed to issue those few refreshes. The request queue is a valid/ready stream. The consumer may stall it freely: a queued row address stays on the output until it is accepted. A request produced while the queue is full is dropped, and the loss is reported on a sticky error pin.

Top module: `srt_refresh_tracker`

## Requirements
- R1: After reset, `req_valid` and `ovf_err` are 0. Row r = seg*ROWS_PER_SEG + idx starts with count 1 + (idx mod CNT_MAX).
- R2: One update tick fires every TICK_CYCLES clocks, starting TICK_CYCLES clocks after reset. On the cycle after a tick, a sweep visits rows seg*ROWS_PER_SEG + idx for seg = 0..NUM_SEGS-1 on consecutive cycles. The current index idx starts at 0 and advances by one after each sweep, wrapping at ROWS_PER_SEG.
- R3: A visit to a row with count 1 lowers it to 0 and enqueues that row's address. A visit to a row with count 0 changes nothing and enqueues nothing. A visit to any other count lowers it by one without a request.
- R4: An access-notify (`acc_valid` with `acc_row`) reloads that row's count to CNT_MAX on the next edge. A row accessed at least once in every 2*ROWS_PER_SEG*TICK_CYCLES clocks is therefore never requested.
- R5: A refresh-done (`done_valid` with `done_row`) reloads that row's count to CNT_MAX.
- R6: If an access-notify or refresh-done names the row being visited in the same cycle, the reload wins: no decrement and no request.
- R7: Requests leave in the order they were enqueued. A request enqueued at a visit edge shows on `req_valid`/`req_row` right after that edge. `req_row` holds while `req_valid` is high and `req_ready` is low. A request is consumed on an edge where both are high.
- R8: The queue holds FIFO_DEPTH requests. A pop in the same cycle does not free space for a push. A request enqueued while the queue is full is dropped and sets `ovf_err`, which stays at 1 until reset.
- R9: With the consumer always ready and each request answered by a refresh-done, every row is reloaded (by access or refresh) at least once per 4*ROWS_PER_SEG*TICK_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A row was activated by normal traffic |
| acc_row | input | ROW_W | Address of the activated row |
| done_valid | input | 1 | A refresh of a row has completed |
| done_row | input | ROW_W | Address of the refreshed row |
| req_valid | output | 1 | A refresh request is waiting |
| req_ready | input | 1 | Consumer accepts the waiting request |
| req_row | output | ROW_W | Row address to refresh |
| ovf_err | output | 1 | Sticky: a request was lost to a full queue |

## Verification
Stimulus on `acc_*`/`done_*` is applied at the falling edge and takes effect at the next rising edge. A request born at the rising edge of a visit is visible on the stream half a cycle later, at the falling edge where the monitor samples. The bench runs an independent cycle model from the requirements at each rising edge. It pushes expected row addresses into a scoreboard queue, modelling the queue's occupancy and the drops caused by a full queue. The monitor pops and compares at every falling edge on which a handshake is seen. The handshake takes effect at the next rising edge, so the model frees the slot only after its own full test on that edge. The retention window and the no-refresh-while-accessed rules are checked in clock counts from the bench's own access and done records.

// File: rtl/srt_pkg.sv
package srt_pkg;
  // Staggered start value for a row at index idx inside its segment.
  function automatic int unsigned stagger_seed(int unsigned idx, int unsigned cmax);
    return 1 + (idx % cmax);
  endfunction
endpackage

// File: rtl/srt_tick_gen.sv
module srt_tick_gen #(
  parameter int unsigned TICK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [TW-1:0] cnt_q;

  assign tick = (cnt_q == TW'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/srt_walker.sv
module srt_walker #(
  parameter int unsigned NUM_SEGS     = 8,
  parameter int unsigned ROWS_PER_SEG = 8,
  parameter int unsigned ROW_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic             visit_valid,
  output logic [ROW_W-1:0] visit_row
);
  localparam int unsigned SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;
  localparam int unsigned IDX_W = (ROWS_PER_SEG > 1) ? $clog2(ROWS_PER_SEG) : 1;
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(NUM_SEGS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROWS_PER_SEG - 1);

  logic             busy_q;
  logic [SEG_W-1:0] seg_q;
  logic [IDX_W-1:0] idx_q;

  assign visit_valid = busy_q;
  assign visit_row   = ROW_W'(32'(seg_q) * ROWS_PER_SEG + 32'(idx_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seg_q  <= '0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (seg_q == SEG_LAST) begin
        busy_q <= 1'b0;
        idx_q  <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      end else begin
        seg_q <= seg_q + 1'b1;
      end
    end else if (tick) begin
      busy_q <= 1'b1;
      seg_q  <= '0;
    end
  end

  // R2
  seg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && seg_q != SEG_LAST) |=> (busy_q && seg_q == $past(seg_q) + 1'b1));
  // R2
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && seg_q == SEG_LAST) |=> !busy_q);
endmodule

// File: rtl/srt_cnt_bank.sv
module srt_cnt_bank #(
  parameter int unsigned NUM_ROWS     = 64,
  parameter int unsigned ROWS_PER_SEG = 8,
  parameter int unsigned ROW_W        = 6,
  parameter int unsigned CNT_W        = 2,
  parameter int unsigned CNT_MAX      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             visit_valid,
  input  logic [ROW_W-1:0] visit_row,
  input  logic             acc_valid,
  input  logic [ROW_W-1:0] acc_row,
  input  logic             done_valid,
  input  logic [ROW_W-1:0] done_row,
  output logic             due,
  output logic [ROW_W-1:0] due_row
);
  logic [CNT_W-1:0] cnts [NUM_ROWS];
  logic             visit_reloaded;

  assign visit_reloaded = (acc_valid && acc_row == visit_row) ||
                          (done_valid && done_row == visit_row);
  assign due     = visit_valid && !visit_reloaded && (cnts[visit_row] == CNT_W'(1));
  assign due_row = visit_row;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    localparam int unsigned INIT = srt_pkg::stagger_seed(r % ROWS_PER_SEG, CNT_MAX);
    logic [CNT_W-1:0] cnt_q;
    logic             hit_reload;
    logic             hit_visit;

    assign hit_reload = (acc_valid && acc_row == ROW_W'(r)) ||
                        (done_valid && done_row == ROW_W'(r));
    assign hit_visit  = visit_valid && visit_row == ROW_W'(r);

    always_ff @(posedge clk) begin
      if (!rst_n)                      cnt_q <= CNT_W'(INIT);
      else if (hit_reload)             cnt_q <= CNT_W'(CNT_MAX);
      else if (hit_visit && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign cnts[r] = cnt_q;
  end

  // R4
  acc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> cnts[$past(acc_row)] == CNT_W'(CNT_MAX));
  // R5
  done_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> cnts[$past(done_row)] == CNT_W'(CNT_MAX));
  // R6
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_valid && acc_valid && acc_row == visit_row) |-> !due);
  // R3
  due_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> cnts[$past(due_row)] == '0);
endmodule

// File: rtl/srt_req_fifo.sv
module srt_req_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ROW_W-1:0] push_row,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ROW_W-1:0] out_row,
  output logic             ovf_err
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OW = $clog2(DEPTH + 1);

  logic [ROW_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [OW-1:0]    occ_q;
  logic             full, do_push, do_pop;

  assign full      = (occ_q == OW'(DEPTH));
  assign do_push   = push && !full;
  assign out_valid = (occ_q != '0);
  assign do_pop    = out_valid && out_ready;
  assign out_row   = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_row;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      occ_q   <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
      if (push && full) ovf_err <= 1'b1;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));
endmodule

// File: rtl/srt_refresh_tracker.sv
module srt_refresh_tracker #(
  parameter int unsigned NUM_ROWS    = 64,
  parameter int unsigned NUM_SEGS    = 8,
  parameter int unsigned CNT_W       = 2,
  parameter int unsigned CNT_MAX     = 3,
  parameter int unsigned TICK_CYCLES = 64,
  parameter int unsigned FIFO_DEPTH  = 2 * NUM_SEGS,
  localparam int unsigned ROW_W      = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [ROW_W-1:0] acc_row,
  input  logic             done_valid,
  input  logic [ROW_W-1:0] done_row,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [ROW_W-1:0] req_row,
  output logic             ovf_err
);
  localparam int unsigned ROWS_PER_SEG = NUM_ROWS / NUM_SEGS;

  logic             tick;
  logic             visit_valid;
  logic [ROW_W-1:0] visit_row;
  logic             due;
  logic [ROW_W-1:0] due_row;

  srt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  srt_walker #(
    .NUM_SEGS(NUM_SEGS), .ROWS_PER_SEG(ROWS_PER_SEG), .ROW_W(ROW_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .visit_valid(visit_valid), .visit_row(visit_row)
  );

  srt_cnt_bank #(
    .NUM_ROWS(NUM_ROWS), .ROWS_PER_SEG(ROWS_PER_SEG), .ROW_W(ROW_W),
    .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .visit_valid(visit_valid), .visit_row(visit_row),
    .acc_valid(acc_valid), .acc_row(acc_row),
    .done_valid(done_valid), .done_row(done_row),
    .due(due), .due_row(due_row)
  );

  srt_req_fifo #(.DEPTH(FIFO_DEPTH), .ROW_W(ROW_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(due), .push_row(due_row),
    .out_valid(req_valid), .out_ready(req_ready), .out_row(req_row),
    .ovf_err(ovf_err)
  );
endmodule

// File: tb/srt_refresh_tracker_tb_top.sv
module srt_refresh_tracker_tb_top;
  localparam int NR    = 32;
  localparam int K     = 4;
  localparam int RPS   = NR / K;
  localparam int TICK  = 12;
  localparam int CMAX  = 3;
  localparam int DEPTH = 2 * K;
  localparam int RW    = $clog2(NR);
  localparam int Q     = RPS * TICK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, done_valid = 1'b0, req_ready = 1'b0;
  logic [RW-1:0] acc_row = '0, done_row = '0;
  logic req_valid, ovf_err;
  logic [RW-1:0] req_row;

  always #10 clk = ~clk;

  srt_refresh_tracker #(
    .NUM_ROWS(NR), .NUM_SEGS(K), .CNT_W(2), .CNT_MAX(CMAX),
    .TICK_CYCLES(TICK), .FIFO_DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row),
    .done_valid(done_valid), .done_row(done_row), .req_valid(req_valid),
    .req_ready(req_ready), .req_row(req_row), .ovf_err(ovf_err)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int phase = 0;         // 0 idle, 1 traffic, 2 stall/drain
  bit finished = 0;

  // ---------------- reference model (rising edge) ----------------
  int m_tcnt, m_seg, m_idx, m_occ;
  bit m_busy, m_ovf, pop_pend;
  int m_cnt [NR];
  int exp_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tcnt = 0; m_busy = 0; m_seg = 0; m_idx = 0; m_occ = 0;
      m_ovf = 0; pop_pend = 0; exp_q.delete();
      for (int r = 0; r < NR; r++) m_cnt[r] = 1 + ((r % RPS) % CMAX);
    end else begin
      bit tk, hit, push;
      int vr;
      tk = (m_tcnt == TICK - 1);
      m_tcnt = tk ? 0 : m_tcnt + 1;
      vr = m_seg * RPS + m_idx;
      hit = (acc_valid && int'(acc_row) == vr) || (done_valid && int'(done_row) == vr);
      push = 0;
      if (m_busy && !hit) begin
        if (m_cnt[vr] == 1) push = 1;
        if (m_cnt[vr] != 0) m_cnt[vr] = m_cnt[vr] - 1;
      end
      if (push) begin
        if (m_occ == DEPTH) m_ovf = 1;
        else begin exp_q.push_back(vr); m_occ++; end
      end
      if (pop_pend) begin m_occ--; pop_pend = 0; end
      if (acc_valid)  m_cnt[acc_row]  = CMAX;
      if (done_valid) m_cnt[done_row] = CMAX;
      if (m_busy) begin
        if (m_seg == K - 1) begin m_busy = 0; m_idx = (m_idx == RPS - 1) ? 0 : m_idx + 1; end
        else m_seg++;
      end else if (tk) begin
        m_busy = 1; m_seg = 0;
      end
    end
  end

  // ---------------- driver + monitor (falling edge) ----------------
  int last_acc [NR];
  int last_serv [NR];
  bit r9_bad [NR];
  int acc_rot = 0, coll_hits = 0;
  bit prev_v = 0, prev_rdy = 0;
  logic [RW-1:0] prev_row = '0;

  task automatic fail_line(string req, int act, int expv);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
  endtask

  always @(negedge clk) begin
    cyc++;
    acc_valid  <= 1'b0;
    done_valid <= 1'b0;
    if (!rst_n) begin
      prev_v = 0;
    end else begin
      // R7: hold while stalled
      if (prev_v && !prev_rdy) begin
        checks++;
        if (!req_valid || req_row != prev_row)
          fail_line("R7 hold", int'(req_row), int'(prev_row));
      end
      if (req_valid && req_ready) begin
        int e;
        checks++;
        if (exp_q.size() == 0) fail_line("R3 R7 unexpected request", int'(req_row), -1);
        else begin
          e = exp_q.pop_front();
          if (int'(req_row) != e) fail_line("R2 R3 R7 request row", int'(req_row), e);
        end
        pop_pend = 1;
        if (phase == 1) begin
          checks++; // R4: no refresh for a row accessed within 2 quarters
          if (cyc - last_acc[req_row] < 2 * Q)
            fail_line("R4 recently accessed row refreshed", cyc - last_acc[req_row], 2 * Q);
        end
        done_valid <= 1'b1;
        done_row   <= req_row;
        last_serv[req_row] = cyc;
      end
      if (phase == 1) begin
        bit drove;
        drove = 0;
        // R6: inject an access on the row being visited when it is about to expire
        if (m_busy && m_cnt[m_seg * RPS + m_idx] == 1 && coll_hits < 6) begin
          int vr;
          vr = m_seg * RPS + m_idx;
          acc_valid <= 1'b1; acc_row <= RW'(vr);
          last_acc[vr] = cyc; last_serv[vr] = cyc;
          coll_hits++; drove = 1;
        end
        if (!drove && cyc % 20 == 0) begin
          int ar;
          ar = (acc_rot * 4) % NR;
          acc_rot++;
          acc_valid <= 1'b1; acc_row <= RW'(ar);
          last_acc[ar] = cyc; last_serv[ar] = cyc;
        end
        for (int r = 0; r < NR; r++)
          if (!r9_bad[r] && cyc - last_serv[r] > 4 * Q) begin
            r9_bad[r] = 1;
            fail_line("R9 row not serviced in interval", cyc - last_serv[r], 4 * Q);
          end
      end
      prev_v = req_valid; prev_rdy = req_ready; prev_row = req_row;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    for (int r = 0; r < NR; r++) begin last_acc[r] = -100000; last_serv[r] = cyc; r9_bad[r] = 0; end
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    checks++; if (req_valid !== 1'b0) fail_line("R1 req_valid at reset", int'(req_valid), 0);
    checks++; if (ovf_err !== 1'b0)   fail_line("R1 ovf_err at reset", int'(ovf_err), 0);

    // Phase 1: traffic, consumer always ready
    @(posedge clk); #1; req_ready = 1'b1; phase = 1;
    repeat (16 * Q) @(posedge clk);
    #1; phase = 0;
    checks++; if (coll_hits == 0) fail_line("R6 collision not exercised", coll_hits, 1);
    checks++; if (ovf_err !== 1'b0) fail_line("R8 spurious overflow", int'(ovf_err), 0);
    for (int r = 0; r < NR; r++) begin
      checks++; // R9 per-row interval result
      if (r9_bad[r]) fail_line("R9 row summary", r, -1);
    end

    // Phase 2: stall the consumer until the queue overflows
    req_ready = 1'b0;
    do_reset();
    phase = 2;
    repeat (2 * Q) @(posedge clk);
    @(negedge clk);
    checks++; if (ovf_err !== 1'b1) fail_line("R8 overflow flag", int'(ovf_err), 1);
    checks++; if (req_valid !== 1'b1) fail_line("R7 valid while stalled", int'(req_valid), 1);
    checks++; if (ovf_err !== m_ovf) fail_line("R8 overflow vs model", int'(ovf_err), int'(m_ovf));
    @(posedge clk); #1; req_ready = 1'b1;
    repeat (2 * Q) @(posedge clk);
    @(negedge clk);
    checks++; if (ovf_err !== 1'b1) fail_line("R8 overflow not sticky", int'(ovf_err), 1);
    checks++; if (req_valid !== (exp_q.size() != 0))
      fail_line("R7 queue occupancy after drain", int'(req_valid), int'(exp_q.size() != 0));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule